// File: doc/BRIEF.md
# Tiled Texture Address Walker

This block produces the address stream for copying a rectangular box of pixels between a plain raster buffer and a texture held in a small-tile layout. In that layout every 64-byte microtile holds a small block of pixels. A start pulse loads the box origin, its size, a pixel-size code and two row pitches. The block then emits one pair of addresses per pixel, in raster order: the byte address inside the tiled surface and the byte address inside the raster buffer. The raster buffer starts at offset 0. A one-cycle done pulse follows the last pair. The block also flags a box whose edges do not fall on microtile boundaries, so that software can choose between a per-pixel copy and a whole-tile copy.

The block never forms a full tiled address from scratch. The horizontal and vertical parts of the address use separate, non-overlapping bit fields. Each part moves by one with a masked subtract: the new value is (value − mask) AND mask. When the vertical part wraps to zero, the row-start horizontal part grows by one row of microtiles.

The address output is a valid/ready stream. A pair is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending pair holds steady and `out_valid` stays high. `start`, `done` and `unaligned` are plain control and status pins.

Top module: `lt_addr_walker`

## Requirements
- R1: After reset, `out_valid` and `done` are low.
- R2: `bpp_sel` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes per pixel. Microtile width is 8, 8, 4 and 2 pixels. Microtile height is 8 for 1 byte per pixel and 4 otherwise. For a pixel at (x, y) with pixel size b and microtile width tw, define X(x) = (x mod tw)·b + (x div tw)·64. The tiled address is X(x) + (y mod th)·tw·b + (y div th)·X(`tile_stride`/b), where th is the microtile height.
- R3: A box of width W and height H produces exactly W·H address pairs, in raster order: x runs fastest, starting at the box origin.
- R4: The linear address of the pixel at column c and row r of the box is r·`lin_stride` + c·b.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and both addresses hold their values on the next cycle.
- R6: `done` is high for exactly one cycle, the cycle after the last pair is transferred, and `out_valid` is low during that cycle.
- R7: A box with zero width or zero height produces no pairs, and `done` rises in the cycle after `start`.
- R8: `unaligned` is high exactly when x, y, width or height is not a multiple of the matching microtile dimension. It is loaded when a walk is accepted and holds its value until the next accepted start.
- R9: A `start` that arrives while a walk is in progress is ignored. The stream and the `unaligned` flag carry on unchanged.
- R10: When a row step crosses a microtile row boundary, the tiled address of the next row includes one more stride step. This also applies to a box whose origin lies partway down a microtile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| box_x | input | CW | Box origin column in pixels |
| box_y | input | CW | Box origin row in pixels |
| box_w | input | CW | Box width in pixels |
| box_h | input | CW | Box height in pixels |
| bpp_sel | input | 2 | Pixel size code: 0=1, 1=2, 2=4, 3=8 bytes |
| tile_stride | input | AW | Tiled surface row pitch in bytes |
| lin_stride | input | AW | Raster buffer row pitch in bytes |
| out_ready | input | 1 | Consumer can take an address pair |
| unaligned | output | 1 | Accepted box is not microtile-aligned |
| out_valid | output | 1 | An address pair is offered |
| tiled_addr | output | AW | Tiled byte address of the current pixel |
| lin_addr | output | AW | Raster byte address of the current pixel |
| done | output | 1 | One-cycle pulse after the final transfer |

## Verification
The hardest case to reach from the ports is a vertical wrap that coincides with back-pressure. The row step, the microtile-row carry into the row-start offset and a stalled output must all happen within a few cycles of each other. The stimulus reaches it by using odd box origins, so that wraps fall in the middle of the box, and by driving `out_ready` randomly or sparsely. Some of those stalls then land on the first pixel of a new microtile row. A spurious `start` is also fired in the middle of a long walk under back-pressure, to show that it leaves the stream unchanged.

// File: rtl/lt_walk_pkg.sv
package lt_walk_pkg;
  typedef enum logic [1:0] {BPP1 = 2'd0, BPP2 = 2'd1, BPP4 = 2'd2, BPP8 = 2'd3} bpp_e;

  // log2 of microtile width in pixels
  function automatic logic [2:0] tile_w_log2(bpp_e code);
    case (code)
      BPP1, BPP2: tile_w_log2 = 3'd3;
      BPP4:       tile_w_log2 = 3'd2;
      default:    tile_w_log2 = 3'd1;
    endcase
  endfunction

  // log2 of microtile height in pixels
  function automatic logic [2:0] tile_h_log2(bpp_e code);
    tile_h_log2 = (code == BPP1) ? 3'd3 : 3'd2;
  endfunction
endpackage

// File: rtl/lt_swizzle.sv
module lt_swizzle
  import lt_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter bit Y_AXIS = 1'b0
) (
  input  logic [AW-1:0] v,
  input  bpp_e          code,
  output logic [AW-1:0] c
);
  generate
    if (Y_AXIS) begin : g_y
      always_comb begin
        case (code)
          BPP1:    c = (v & AW'(7)) << 3;
          default: c = (v & AW'(3)) << 4;
        endcase
      end
    end else begin : g_x
      always_comb begin
        case (code)
          BPP1:    c = (v & AW'(7))        | ((v & ~AW'(7)) << 3);
          BPP2:    c = ((v & AW'(7)) << 1) | ((v & ~AW'(7)) << 3);
          BPP4:    c = ((v & AW'(3)) << 2) | ((v & ~AW'(3)) << 4);
          default: c = ((v & AW'(1)) << 3) | ((v & ~AW'(1)) << 5);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/lt_align_check.sv
module lt_align_check
  import lt_walk_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  bpp_e          code,
  output logic          misaligned
);
  logic [CW-1:0] wmask, hmask;
  always_comb begin
    wmask = (CW'(1) << tile_w_log2(code)) - CW'(1);
    hmask = (CW'(1) << tile_h_log2(code)) - CW'(1);
    misaligned = |(x & wmask) | |(w & wmask) | |(y & hmask) | |(h & hmask);
  end
endmodule

// File: rtl/lt_walk_core.sv
module lt_walk_core #(
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [AW-1:0] x_init,
  input  logic [AW-1:0] y_init,
  input  logic [AW-1:0] row_incr,
  input  logic [AW-1:0] x_mask,
  input  logic [AW-1:0] y_mask,
  input  logic [AW-1:0] pix_bytes,
  input  logic [AW-1:0] lin_pitch,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] tiled,
  output logic [AW-1:0] lin,
  output logic          done
);
  logic          active;
  logic [CW-1:0] col, row, w_q, h_q;
  logic [AW-1:0] xrow, xcur, ycur, xm, ym, incr_q, lrow, lcur, step_q, lstr_q;
  logic [AW-1:0] x_next, y_next, xrow_next, lrow_next;
  logic          last_col, last_row, fire;

  always_comb begin
    fire      = active & ready;
    last_col  = (col == w_q - CW'(1));
    last_row  = (row == h_q - CW'(1));
    x_next    = (xcur - xm) & xm;
    y_next    = (ycur - ym) & ym;
    xrow_next = (y_next == '0) ? xrow + incr_q : xrow;
    lrow_next = lrow + lstr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0;
      col <= '0; row <= '0; w_q <= '0; h_q <= '0;
      xrow <= '0; xcur <= '0; ycur <= '0; xm <= '0; ym <= '0;
      incr_q <= '0; lrow <= '0; lcur <= '0; step_q <= '0; lstr_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active <= (width != '0) && (height != '0);
        done   <= (width == '0) || (height == '0);
        col <= '0; row <= '0; w_q <= width; h_q <= height;
        xrow <= x_init; xcur <= x_init; ycur <= y_init;
        xm <= x_mask; ym <= y_mask; incr_q <= row_incr;
        lrow <= '0; lcur <= '0; step_q <= pix_bytes; lstr_q <= lin_pitch;
      end else if (fire) begin
        if (last_col) begin
          col <= '0;
          if (last_row) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            row  <= row + CW'(1);
            ycur <= y_next;
            xrow <= xrow_next;
            xcur <= xrow_next;
            lrow <= lrow_next;
            lcur <= lrow_next;
          end
        end else begin
          col  <= col + CW'(1);
          xcur <= x_next;
          lcur <= lcur + step_q;
        end
      end
    end
  end

  assign valid = active;
  assign tiled = xcur + ycur;
  assign lin   = lcur;

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid); // R5
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> $stable(tiled) && $stable(lin)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid); // R6
  AST_FIELDS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((xcur & ycur) == '0)); // R2
endmodule

// File: rtl/lt_addr_walker.sv
module lt_addr_walker
  import lt_walk_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] box_x,
  input  logic [CW-1:0] box_y,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [1:0]    bpp_sel,
  input  logic [AW-1:0] tile_stride,
  input  logic [AW-1:0] lin_stride,
  input  logic          out_ready,
  output logic          unaligned,
  output logic          out_valid,
  output logic [AW-1:0] tiled_addr,
  output logic [AW-1:0] lin_addr,
  output logic          done
);
  localparam int PAD = AW - CW;

  bpp_e          code;
  logic          load, misaligned;
  logic [AW-1:0] org_x, org_y, stride_px, rows_above, pix_bytes;
  logic [AW-1:0] sx, sy, sincr, xmask, ymask, x_init;

  always_comb begin
    code       = bpp_e'(bpp_sel);
    load       = start && !out_valid;
    org_x      = {{PAD{1'b0}}, box_x};
    org_y      = {{PAD{1'b0}}, box_y};
    stride_px  = tile_stride >> bpp_sel;
    rows_above = org_y >> tile_h_log2(code);
    pix_bytes  = AW'(1) << bpp_sel;
    x_init     = sx + sincr * rows_above;
  end

  lt_swizzle #(.AW(AW), .Y_AXIS(1'b0)) i_sw_x     (.v(org_x),     .code(code), .c(sx));
  lt_swizzle #(.AW(AW), .Y_AXIS(1'b1)) i_sw_y     (.v(org_y),     .code(code), .c(sy));
  lt_swizzle #(.AW(AW), .Y_AXIS(1'b0)) i_sw_incr  (.v(stride_px), .code(code), .c(sincr));
  lt_swizzle #(.AW(AW), .Y_AXIS(1'b0)) i_sw_xmask (.v('1),        .code(code), .c(xmask));
  lt_swizzle #(.AW(AW), .Y_AXIS(1'b1)) i_sw_ymask (.v('1),        .code(code), .c(ymask));

  lt_align_check #(.CW(CW)) i_align (
    .x(box_x), .y(box_y), .w(box_w), .h(box_h), .code(code), .misaligned(misaligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unaligned <= 1'b0;
    else if (load) unaligned <= misaligned;
  end

  lt_walk_core #(.CW(CW), .AW(AW)) i_core (
    .clk(clk), .rst_n(rst_n), .load(load),
    .width(box_w), .height(box_h),
    .x_init(x_init), .y_init(sy), .row_incr(sincr),
    .x_mask(xmask), .y_mask(ymask),
    .pix_bytes(pix_bytes), .lin_pitch(lin_stride),
    .ready(out_ready), .valid(out_valid),
    .tiled(tiled_addr), .lin(lin_addr), .done(done)
  );

  AST_ZERO_BOX: assert property (@(posedge clk) disable iff (!rst_n)
    load && (box_w == '0 || box_h == '0) |=> done && !out_valid); // R7
  AST_BUSY_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$fell(out_valid) |=> $stable(unaligned) || $past(load)); // R9
endmodule

// File: tb/test_lt_addr_walker.sv
module test_lt_addr_walker;
  localparam int CW = 12;
  localparam int AW = 32;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] box_x = '0, box_y = '0, box_w = '0, box_h = '0;
  logic [1:0]    bpp_sel = '0;
  logic [AW-1:0] tile_stride = '0, lin_stride = '0;
  logic          out_ready = 1'b0;
  logic          unaligned, out_valid, done;
  logic [AW-1:0] tiled_addr, lin_addr;

  int unsigned q_t[$];
  int unsigned q_l[$];
  int  checks = 0, errors = 0;
  int  rmode = 0;
  bit  running = 1'b0, done_due = 1'b0, done_seen = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lt_addr_walker #(.CW(CW), .AW(AW)) i_lt_addr_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .box_x(box_x), .box_y(box_y), .box_w(box_w), .box_h(box_h),
    .bpp_sel(bpp_sel), .tile_stride(tile_stride), .lin_stride(lin_stride),
    .out_ready(out_ready), .unaligned(unaligned), .out_valid(out_valid),
    .tiled_addr(tiled_addr), .lin_addr(lin_addr), .done(done)
  );

  task automatic ck(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned tw(int b);
    return (b <= 2) ? 8 : (b == 4) ? 4 : 2;
  endfunction
  function automatic int unsigned th(int b);
    return (b == 1) ? 8 : 4;
  endfunction
  function automatic int unsigned xf(int unsigned x, int b);
    return (x % tw(b)) * b + (x / tw(b)) * 64;
  endfunction

  // ready driver
  always @(posedge clk) begin
    #1;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = $urandom_range(1, 0) == 1;
      default: out_ready = $urandom_range(3, 0) == 0;
    endcase
  end

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n && running) begin
      bit nd;
      ck(done == done_due, "R6/R7 done timing", done, done_due);
      if (done) done_seen = 1'b1;
      nd = 1'b0;
      if (start && !out_valid && (box_w == 0 || box_h == 0)) nd = 1'b1;
      if (out_valid) begin
        if (q_t.size() == 0) ck(1'b0, "R3 extra address", tiled_addr, 0);
        else if (out_ready) begin
          ck(tiled_addr == q_t[0], "R2/R10 tiled address", tiled_addr, q_t[0]);
          ck(lin_addr == q_l[0], "R4 linear address", lin_addr, q_l[0]);
          void'(q_t.pop_front());
          void'(q_l.pop_front());
          if (q_t.size() == 0) nd = 1'b1;
        end
      end
      done_due = nd;
    end
  end

  task automatic run_box(int x, int y, int w, int h, int code, int stride,
                         int lstr, int mode, bit spam);
    int b = 1 << code;
    bit exp_un;
    exp_un = (x % tw(b) != 0) || (w % tw(b) != 0) || (y % th(b) != 0) || (h % th(b) != 0);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        q_t.push_back(xf(x + c, b) + ((y + r) % th(b)) * tw(b) * b
                      + ((y + r) / th(b)) * xf(stride / b, b));
        q_l.push_back(r * lstr + c * b);
      end
    @(posedge clk); #1;
    rmode = mode;
    done_seen = 1'b0;
    box_x = CW'(x); box_y = CW'(y); box_w = CW'(w); box_h = CW'(h);
    bpp_sel = 2'(code); tile_stride = AW'(stride); lin_stride = AW'(lstr);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (spam) begin
      // R9: second start mid-walk with a different, aligned box
      repeat (3) @(posedge clk);
      #1;
      box_x = '0; box_y = '0; box_w = CW'(4); box_h = CW'(4); bpp_sel = 2'd2;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    ck(q_t.size() == 0, "R3 pair count", q_t.size(), 0);
    ck(unaligned == exp_un, spam ? "R9 flag kept" : "R8 unaligned flag", unaligned, exp_un);
    @(negedge clk);
    ck(!out_valid, "R6 idle after done", out_valid, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    ck(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    ck(!out_valid, "R1 reset valid", out_valid, 0);
    ck(!done, "R1 reset done", done, 0);
    running = 1'b1;
    run_box(0, 0, 8, 8, 2, 256, 32, 0, 1'b0);   // aligned 4B
    run_box(3, 5, 13, 11, 0, 64, 13, 1, 1'b0);  // 1B, R10 mid-tile origin
    run_box(6, 3, 5, 6, 1, 128, 20, 1, 1'b1);   // 2B, R9 spurious start
    run_box(1, 2, 3, 7, 3, 256, 64, 2, 1'b0);   // 8B sparse ready
    run_box(4, 8, 4, 4, 2, 128, 16, 1, 1'b0);   // aligned, offset origin
    run_box(2, 9, 0, 5, 0, 64, 8, 0, 1'b0);     // R7 zero width
    run_box(2, 9, 5, 0, 1, 64, 8, 0, 1'b0);     // R7 zero height
    run_box(7, 7, 1, 1, 3, 512, 8, 2, 1'b0);    // single pixel
    run_box(5, 1, 9, 14, 2, 192, 40, 2, 1'b0);  // R10 several wraps
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule